// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block lets clocked logic use an external asynchronous static RAM of 512K words by 16 bits. On the request side it takes one access at a time through a valid/ready handshake. Each request carries a write flag, a 19-bit word address, 16 bits of write data and two byte-enable bits. A read returns its data together with a one-cycle valid pulse.

On the memory side the block drives active-low chip-enable, write-enable, output-enable and per-byte select strobes, the address bus, and a data bus split into an output, a drive-enable and an input. It builds every phase of a memory cycle from a whole number of clock cycles. Each count comes from a nanosecond timing parameter and the clock period, using ceil(t_ns / period), and no phase is shorter than one cycle.

A write frames its strobe inside a window where chip-enable is low and write-enable is high, so the address and data are already settled before write-enable falls and stay put until after it rises. When a write comes straight after a read, the block waits out the memory's output-float time before it drives the bus.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and whenever `req_ready` is high, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_be_n` is 2'b11 and `mem_dq_oe` is 0.
- R2: A read accepted at clock edge E holds `mem_ce_n` and `mem_oe_n` low for RD cycles, where RD = ceil(max(t_rc, t_aa) / period). `rsp_valid` is high for exactly one cycle after edge E+RD. At that edge `rsp_rdata` captures `mem_dq_in`.
- R3: During an access, `mem_be_n[i]` is the inverse of `req_be[i]`. Bit 0 is the lower byte (data bits 7..0) and bit 1 is the upper byte (bits 15..8). In a read, only the selected lanes of `rsp_rdata` are defined.
- R4: A write holds chip-enable low and write-enable high for SU = ceil(t_as / period) cycles. Write-enable then stays low for WP cycles, where WP = max(ceil(t_wp/period), ceil(t_dw/period), ceil(t_wc/period) - SU - REC). Write-enable then stays high for REC = ceil(t_wr / period) cycles before chip-enable rises. Write-enable is never low while chip-enable is high.
- R5: The address and the driven write data do not change while `mem_we_n` is low.
- R6: A write changes only the byte lanes whose `req_be` bit is 1. The other lane keeps its previous contents.
- R7: A write accepted directly after a read spends TA = ceil(t_ohz / period) cycles deselected before its setup phase. A write that follows a write starts its setup phase at once.
- R8: The block never drives the data bus while the memory may be driving it. That covers the whole time output-enable is low with chip selected, and the t_ohz window after output-enable rises.
- R9: `req_ready` is high only in the idle state. A request is accepted on an edge where both `req_valid` and `req_ready` are high, and `req_ready` is low in the cycle after that edge.
- R10: Within one write, chip-enable is low for at least ceil(t_wc / period) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = bits 7..0 |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | 16 | Captured read data |
| mem_addr | output | 19 | Memory address bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_be_n | output | 2 | Byte-lane selects, active low, bit 0 = lower |
| mem_dq_out | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data returned by memory |

## Verification
Each read's expected data goes into a queue along with the cycle it is due in. That cycle is the accepting edge plus RD. A monitor samples on the falling edge and flags any response that arrives one cycle early or late, or carries wrong data. Because the behavioural memory returns valid data only after RD full cycles have elapsed, a capture taken too soon shows up as a data error.

For writes, the bench counts the falling edges from acceptance to the first low write-enable: SU+1 after a write, and TA+SU+1 after a read. The memory model checks the strobe width, the chip-enable span, and address and data stability on every cycle. It also looks for bus contention inside the float window that follows each read.

// File: rtl/sram_async_pkg.sv
package sram_async_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_RD_ACCESS  = 3'd1,
    ST_WR_SETUP   = 3'd2,
    ST_WR_PULSE   = 3'd3,
    ST_WR_RECOVER = 3'd4,
    ST_TURNAROUND = 3'd5
  } ctrl_state_e;

  // Round a nanosecond figure up to whole clock cycles, never below one.
  function automatic int ns_to_cycles(input int t_ns, input int per_ns);
    int c;
    c = (t_ns + per_ns - 1) / per_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // A new phase may only start once the previous one has run out.
  AST_LOAD_ON_EXPIRY: assert property (@(posedge clk) disable iff (rst)
    load |-> expired); // R2

endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane #(
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              en_in,
  input  logic [LANE_W-1:0] byte_in,
  input  logic              active_nx,
  output logic              sel_n,
  output logic [LANE_W-1:0] byte_out
);

  logic en_q;
  logic en_nx;

  assign en_nx = accept ? en_in : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      sel_n    <= 1'b1;
      byte_out <= '0;
    end else begin
      en_q  <= en_nx;
      sel_n <= ~(active_nx & en_nx);
      if (accept) byte_out <= byte_in;
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_async_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS       = 55,
  parameter int T_AA_NS       = 55,
  parameter int T_WC_NS       = 55,
  parameter int T_AS_NS       = 0,
  parameter int T_WP_NS       = 30,
  parameter int T_DW_NS       = 25,
  parameter int T_WR_NS       = 0,
  parameter int T_OHZ_NS      = 25
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_ce_n,
  output logic                mem_we_n,
  output logic                mem_oe_n,
  output logic [DATA_W/8-1:0] mem_be_n,
  output logic [DATA_W-1:0]   mem_dq_out,
  output logic                mem_dq_oe,
  input  logic [DATA_W-1:0]   mem_dq_in
);

  localparam int LANES   = DATA_W / 8;
  localparam int RD_CYC  = ns_to_cycles(imax(T_RC_NS, T_AA_NS), CLK_PERIOD_NS);
  localparam int SU_CYC  = ns_to_cycles(T_AS_NS, CLK_PERIOD_NS);
  localparam int REC_CYC = ns_to_cycles(T_WR_NS, CLK_PERIOD_NS);
  localparam int WC_CYC  = ns_to_cycles(T_WC_NS, CLK_PERIOD_NS);
  localparam int WP_CYC  = imax(imax(ns_to_cycles(T_WP_NS, CLK_PERIOD_NS),
                                     ns_to_cycles(T_DW_NS, CLK_PERIOD_NS)),
                                WC_CYC - SU_CYC - REC_CYC);
  localparam int TA_CYC  = ns_to_cycles(T_OHZ_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC = imax(imax(RD_CYC, WP_CYC), imax(TA_CYC, imax(SU_CYC, REC_CYC)));
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  ctrl_state_e      state_q, state_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;
  logic             accept;
  logic             last_rd_q;
  logic             rd_done;
  logic             active_nx;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign rd_done   = (state_q == ST_RD_ACCESS) && tmr_expired;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (req_valid) begin
        tmr_load = 1'b1;
        if (!req_write) begin
          state_d = ST_RD_ACCESS;
          tmr_val = CNT_W'(RD_CYC - 1);
        end else if (last_rd_q) begin
          state_d = ST_TURNAROUND;
          tmr_val = CNT_W'(TA_CYC - 1);
        end else begin
          state_d = ST_WR_SETUP;
          tmr_val = CNT_W'(SU_CYC - 1);
        end
      end
      ST_RD_ACCESS: if (tmr_expired) state_d = ST_IDLE;
      ST_TURNAROUND: if (tmr_expired) begin
        state_d  = ST_WR_SETUP;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(SU_CYC - 1);
      end
      ST_WR_SETUP: if (tmr_expired) begin
        state_d  = ST_WR_PULSE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WP_CYC - 1);
      end
      ST_WR_PULSE: if (tmr_expired) begin
        state_d  = ST_WR_RECOVER;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(REC_CYC - 1);
      end
      ST_WR_RECOVER: if (tmr_expired) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign active_nx = (state_d == ST_RD_ACCESS) || (state_d == ST_WR_SETUP) ||
                     (state_d == ST_WR_PULSE)  || (state_d == ST_WR_RECOVER);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      last_rd_q <= 1'b0;
      mem_ce_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_dq_oe <= 1'b0;
      mem_addr  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      state_q   <= state_d;
      mem_ce_n  <= ~active_nx;
      mem_oe_n  <= ~(state_d == ST_RD_ACCESS);
      mem_we_n  <= ~(state_d == ST_WR_PULSE);
      mem_dq_oe <= (state_d == ST_WR_SETUP) || (state_d == ST_WR_PULSE) ||
                   (state_d == ST_WR_RECOVER);
      if (accept) mem_addr <= req_addr;
      if (rd_done) last_rd_q <= 1'b1;
      else if (accept && req_write) last_rd_q <= 1'b0;
      rsp_valid <= rd_done;
      if (rd_done) rsp_rdata <= mem_dq_in;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_byte_lane #(.LANE_W(8)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .accept    (accept),
      .en_in     (req_be[g]),
      .byte_in   (req_wdata[g*8 +: 8]),
      .active_nx (active_nx),
      .sel_n     (mem_be_n[g]),
      .byte_out  (mem_dq_out[g*8 +: 8])
    );
  end

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> !mem_ce_n); // R4
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n); // R8
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |=> (mem_we_n || $stable(mem_addr))); // R5
  AST_WDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |=> (mem_we_n || $stable(mem_dq_out))); // R5
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R2
  AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && !mem_dq_oe && mem_oe_n)); // R1
  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R9

endmodule

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;

  localparam int PER    = 8;
  localparam int AW     = 19;
  localparam int DW     = 16;
  // Expected phase lengths, worked out from the requirements at 8 ns.
  localparam int B_RD   = (55 + PER - 1) / PER;
  localparam int B_SU   = 1;
  localparam int B_REC  = 1;
  localparam int B_WC   = (55 + PER - 1) / PER;
  localparam int B_WP0  = (30 + PER - 1) / PER;
  localparam int B_WP   = (B_WC - B_SU - B_REC > B_WP0) ? (B_WC - B_SU - B_REC) : B_WP0;
  localparam int B_TA   = (25 + PER - 1) / PER;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0]    req_be = 2'b00;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [1:0]    mem_be_n;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] dq_in_r = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(PER/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sram_async_ctrl #(.CLK_PERIOD_NS(PER)) u_sram_async_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_be_n(mem_be_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(dq_in_r)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // ---------------- behavioural memory ----------------
  logic [DW-1:0] mem [int];
  int  rd_age = 0;
  logic [AW-1:0] rd_addr = '0;
  int  hold = 0;
  bit  prev_oe_low = 0;
  bit  prev_wlow = 0;
  int  wcount = 0;
  logic [AW-1:0] waddr = '0;
  logic [DW-1:0] wdata = '0;
  int  ce_cnt = 0;
  bit  wr_seen = 0;
  int  fight_err = 0;
  int  stab_err = 0;
  int  idle_err = 0;
  int  idle_seen = 0;

  always @(negedge clk) begin
    logic [DW-1:0] word;
    bit rd_mode, wlow;
    if (!rst) begin
      rd_mode = !mem_ce_n && !mem_oe_n && mem_we_n;
      wlow    = !mem_ce_n && !mem_we_n;
      // R8: controller must not drive while memory drives or floats
      if (mem_dq_oe && (rd_mode || hold > 0)) fight_err++;
      if (hold > 0) hold--;
      if (prev_oe_low && !rd_mode) hold = B_TA - 1;
      prev_oe_low = rd_mode;
      // read access age
      if (rd_mode) begin
        if (rd_age == 0 || mem_addr == rd_addr) rd_age++;
        else rd_age = 1;
        rd_addr = mem_addr;
      end else rd_age = 0;
      word = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 16'h0000;
      if (rd_mode) begin
        if (rd_age * PER >= 55) dq_in_r = word;
        else dq_in_r = 16'hDEAD;
        if (mem_be_n[0]) dq_in_r[7:0]  = 8'h00;
        if (mem_be_n[1]) dq_in_r[15:8] = 8'h00;
      end else dq_in_r = 16'hBEEF;
      // write strobe tracking
      if (wlow) begin
        if (wcount > 0 && (mem_addr != waddr || mem_dq_out != wdata)) stab_err++; // R5
        waddr = mem_addr;
        wdata = mem_dq_out;
        wcount++;
        wr_seen = 1;
      end else if (prev_wlow) begin
        word = mem.exists(int'(waddr)) ? mem[int'(waddr)] : 16'h0000;
        if (!mem_be_n[0]) word[7:0]  = mem_dq_out[7:0];
        if (!mem_be_n[1]) word[15:8] = mem_dq_out[15:8];
        mem[int'(waddr)] = word;
        chk(wcount == B_WP, "R4", "write strobe cycles", wcount, B_WP);
        wcount = 0;
      end
      prev_wlow = wlow;
      // chip-enable span of a write
      if (!mem_ce_n) ce_cnt++;
      else begin
        if (wr_seen) chk(ce_cnt >= B_WC, "R10", "write ce low cycles", ce_cnt, B_WC);
        ce_cnt = 0;
        wr_seen = 0;
      end
      // R1: idle pins
      if (req_ready) begin
        idle_seen++;
        if (!(mem_ce_n && mem_we_n && mem_oe_n && mem_be_n == 2'b11 && !mem_dq_oe)) idle_err++;
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [DW-1:0] d;
    logic [DW-1:0] m;
    int            due;
  } exp_t;
  exp_t q[$];
  logic [DW-1:0] shadow [int];
  bit last_was_read = 0;

  always @(negedge clk) begin
    exp_t e;
    if (!rst && rsp_valid) begin
      if (q.size() == 0) chk(0, "R2", "unexpected rsp_valid", 1, 0);
      else begin
        e = q.pop_front();
        chk(cyc == e.due, "R2", "read response cycle", cyc, e.due);
        chk((rsp_rdata & e.m) == (e.d & e.m), "R3", "read data (selected lanes)",
            rsp_rdata & e.m, e.d & e.m);
      end
    end
  end

  task automatic issue(input bit wr, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [1:0] be);
    int c0, n, exp_n;
    logic [DW-1:0] m, w;
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    while (!req_ready) @(negedge clk);
    c0 = cyc;
    m = {{8{be[1]}}, {8{be[0]}}};
    if (!wr) begin
      e.d = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
      e.m = m; e.due = c0 + 1 + B_RD;
      q.push_back(e);
    end else begin
      w = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
      w = (w & ~m) | (d & m);
      shadow[int'(a)] = w;
    end
    exp_n = last_was_read ? (B_TA + B_SU + 1) : (B_SU + 1);
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    n = 1;
    chk(req_ready == 1'b0, "R9", "ready low after accept", req_ready, 0);
    if (wr) begin
      while (mem_we_n && n < 40) begin
        @(negedge clk);
        n++;
      end
      chk(n == exp_n, "R7", last_was_read ? "write start after read" : "write start after write",
          n, exp_n);
    end
    last_was_read = !wr;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "ALL", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // reset state (R1, R9)
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1", "strobes idle in reset",
        {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
    chk(mem_be_n == 2'b11 && !mem_dq_oe, "R1", "lanes idle in reset", {mem_be_n, mem_dq_oe}, 3'b110);
    chk(rsp_valid == 1'b0, "R2", "no response in reset", rsp_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready after reset", req_ready, 1);

    issue(1, 19'h00010, 16'h1234, 2'b11);      // write after nothing: no turnaround
    issue(1, 19'h7FFFF, 16'hAAAA, 2'b11);      // top address, write after write
    issue(1, 19'h00000, 16'h5555, 2'b11);
    issue(0, 19'h00010, 16'h0000, 2'b11);      // read
    issue(1, 19'h00010, 16'hABCD, 2'b01);      // R6: lower lane only, after read -> turnaround
    issue(0, 19'h00010, 16'h0000, 2'b11);      // expect 12CD
    issue(1, 19'h00010, 16'h56FF, 2'b10);      // R6: upper lane only
    issue(0, 19'h00010, 16'h0000, 2'b11);      // expect 56CD
    issue(0, 19'h7FFFF, 16'h0000, 2'b01);      // R3: lower-lane read
    issue(0, 19'h00000, 16'h0000, 2'b10);      // R3: upper-lane read
    issue(0, 19'h7FFFF, 16'h0000, 2'b11);      // back-to-back reads
    issue(1, 19'h2A5A5, 16'h0F0F, 2'b00);      // R6: no lane enabled
    issue(1, 19'h2A5A5, 16'hC3C3, 2'b11);
    issue(1, 19'h2A5A5, 16'h9999, 2'b00);      // must leave C3C3
    issue(0, 19'h2A5A5, 16'h0000, 2'b11);

    while (q.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(fight_err == 0, "R8", "bus contention events", fight_err, 0);
    chk(stab_err == 0, "R5", "address/data changes under strobe", stab_err, 0);
    chk(idle_err == 0 && idle_seen > 0, "R1", "idle pin violations", idle_err, 0);
    summary();
    $finish;
  end

endmodule